// File: doc/BRIEF.md
# Endpoint Packet Buffer Segment Allocator

This block manages the space of one endpoint packet buffer. The buffer is split into 512-byte units, and a register map of 128 bits, one bit for each unit, records which units are taken. A client asks for space by giving the endpoint's maximum packet size and a slot count. The block works out how many units that needs, looks for the lowest free run of that many units, claims it, and answers with a byte address. A client gives space back by naming the address and the same size inputs. The block clears exactly those units.

The block sizes a request in three steps. The packet size is rounded up to a power of two, which gives the segment size. The segment size is multiplied by one more than the slot count. The result is then rounded up to whole units. A request can also pick a default slot count in place of its own. That default is two for a core that runs at SuperSpeed and one for a core limited to high speed. A run-time unit limit caps how much of the map may be handed out. The base address input places the buffer in the address space. One instance serves the transmit buffer and another serves the receive buffer.

Top module: `fifo_seg_alloc`

## Requirements
- R1: After reset, `req_ready_o` is 1, `done_o`, `fail_o`, `free_err_o` are 0, `rsp_addr_o` is 0, and every unit is free, so the first allocation starts at unit 0.
- R2: The unit count of a request is ceil((slot+1) * P / 512), where P is the smallest power of two not below `req_maxp_i`, with a minimum of 1.
- R3: When `req_dflt_slot_i` is 1, `req_slot_i` is ignored and the slot count is 2, or 1 if the parameter `HS_ONLY` is set.
- R4: An allocation claims the lowest-numbered run of free units that is long enough. It reports `base_addr_i` + start_unit*512 on `rsp_addr_o` with `done_o`=1 and `fail_o`=0.
- R5: An allocation uses only units below min(`unit_limit_i`, 128), and a run may end exactly at that limit. If no run fits, `done_o` and `fail_o` pulse together and the map is unchanged.
- R6: A free request (`req_free_i`=1) covers the units from (`req_addr_i` - `base_addr_i`)/512 for the computed unit count. It clears exactly those units, and the cycle after acceptance it shows `done_o`=1 with `rsp_addr_o` set to the address of the first freed unit.
- R7: A free request that covers any unit already clear, or that reaches past the unit limit, pulses `done_o` with `free_err_o`=1 and leaves the map unchanged.
- R8: While an allocation searches, `req_ready_o` is 0 and requests are ignored. The search finishes within limit+2 cycles of acceptance.
- R9: `fail_o` and `free_err_o` are only high together with `done_o` and never both at once. `rsp_addr_o` changes only in a `done_o` cycle, and `done_o` is only high while `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_addr_i | input | ADDR_W | Byte address of unit 0 |
| unit_limit_i | input | log2(UNITS)+1 | Number of units that may be used |
| req_valid_i | input | 1 | Request strobe, taken when `req_ready_o` is 1 |
| req_free_i | input | 1 | 0: allocate, 1: free |
| req_maxp_i | input | MAXP_W | Endpoint maximum packet size in bytes |
| req_slot_i | input | SLOT_W | Slot count |
| req_dflt_slot_i | input | 1 | Use the built-in default slot count |
| req_addr_i | input | ADDR_W | Start address of the region to free |
| req_ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Allocation found no fitting run |
| free_err_o | output | 1 | Free request rejected |
| rsp_addr_o | output | ADDR_W | Allocated or freed start address |

## Verification
The hardest states to reach are a freed hole between allocated regions and a request made while a search is running. Allocations and frees are sequenced to leave holes of known sizes. Later allocations must then land in, or skip, those holes, and a bad free must be shown to leave the map untouched. A free request is driven during a long search, and a follow-up allocation must not land in the region that free named.

// File: rtl/fifo_seg_pkg.sv
`timescale 1ns/1ps
package fifo_seg_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_SCAN = 1'b1
    } fs_state_e;
endpackage

// File: rtl/fseg_sizer.sv
`timescale 1ns/1ps
module fseg_sizer #(
    parameter int MAXP_W  = 11,
    parameter int SLOT_W  = 3,
    parameter int UNIT_LG = 9,
    parameter int CNT_W   = 8
) (
    input  logic [MAXP_W-1:0] maxp_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [CNT_W-1:0]  units_o
);
    localparam int TOT_W = MAXP_W + SLOT_W + 2;
    localparam logic [TOT_W-1:0] CNT_MAX = TOT_W'((1 << CNT_W) - 1);
    localparam logic [TOT_W-1:0] RND_ADD = TOT_W'((1 << UNIT_LG) - 1);

    logic [TOT_W-1:0] seg;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] rnd;

    always_comb begin
        seg = TOT_W'(1);
        for (int k = 0; k < MAXP_W; k++) begin
            if (seg < TOT_W'(maxp_i)) begin
                seg = seg << 1;
            end
        end
        total = seg * (TOT_W'(slot_i) + TOT_W'(1));
        rnd   = (total + RND_ADD) >> UNIT_LG;
        if (rnd == '0) begin
            units_o = CNT_W'(1);
        end else if (rnd > CNT_MAX) begin
            units_o = '1;
        end else begin
            units_o = rnd[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/fseg_mask.sv
`timescale 1ns/1ps
module fseg_mask #(
    parameter int UNITS = 128,
    parameter int OFS_W = 23,
    parameter int CNT_W = 8
) (
    input  logic [OFS_W-1:0] start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic [UNITS-1:0] mask_o
);
    localparam int EW = OFS_W + 1;

    logic [EW-1:0] end_x;
    assign end_x = EW'(start_i) + EW'(len_i);

    for (genvar i = 0; i < UNITS; i++) begin : g_bit
        assign mask_o[i] = (EW'(i) >= EW'(start_i)) && (EW'(i) < end_x);
    end
endmodule

// File: rtl/fifo_seg_alloc.sv
`timescale 1ns/1ps
module fifo_seg_alloc #(
    parameter int UNITS   = 128,
    parameter int UNIT_LG = 9,
    parameter int ADDR_W  = 32,
    parameter int MAXP_W  = 11,
    parameter int SLOT_W  = 3,
    parameter bit HS_ONLY = 1'b0
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [ADDR_W-1:0]          base_addr_i,
    input  logic [$clog2(UNITS):0]     unit_limit_i,
    input  logic                       req_valid_i,
    input  logic                       req_free_i,
    input  logic [MAXP_W-1:0]          req_maxp_i,
    input  logic [SLOT_W-1:0]          req_slot_i,
    input  logic                       req_dflt_slot_i,
    input  logic [ADDR_W-1:0]          req_addr_i,
    output logic                       req_ready_o,
    output logic                       done_o,
    output logic                       fail_o,
    output logic                       free_err_o,
    output logic [ADDR_W-1:0]          rsp_addr_o
);
    import fifo_seg_pkg::*;

    localparam int IDX_W = $clog2(UNITS);
    localparam int CNT_W = IDX_W + 1;
    localparam int OFS_W = ADDR_W - UNIT_LG;
    localparam logic [SLOT_W-1:0] DFLT_SLOT = HS_ONLY ? SLOT_W'(1) : SLOT_W'(2);
    localparam logic [CNT_W-1:0]  UNITS_C   = CNT_W'(UNITS);

    typedef struct packed {
        fs_state_e          st;
        logic [UNITS-1:0]   bmap;
        logic [CNT_W-1:0]   idx;
        logic [CNT_W-1:0]   run_start;
        logic [CNT_W-1:0]   run_len;
        logic [CNT_W-1:0]   need;
        logic [CNT_W-1:0]   limit;
        logic [ADDR_W-1:0]  base;
        logic               done;
        logic               fail;
        logic               ferr;
        logic [ADDR_W-1:0]  addr;
    } fs_regs_t;

    fs_regs_t r_d, r_q;

    logic [SLOT_W-1:0] slot_eff;
    logic [CNT_W-1:0]  units_req;
    logic [ADDR_W-1:0] ofs;
    logic [OFS_W-1:0]  fstart;
    logic [CNT_W-1:0]  lim_eff;
    logic [OFS_W-1:0]  m_start;
    logic [CNT_W-1:0]  m_len;
    logic [UNITS-1:0]  run_mask;
    logic              range_bad;
    logic              clear_bad;

    assign slot_eff = req_dflt_slot_i ? DFLT_SLOT : req_slot_i;
    assign ofs      = req_addr_i - base_addr_i;
    assign fstart   = OFS_W'(ofs >> UNIT_LG);
    assign lim_eff  = (unit_limit_i > UNITS_C) ? UNITS_C : unit_limit_i;

    fseg_sizer #(
        .MAXP_W  (MAXP_W),
        .SLOT_W  (SLOT_W),
        .UNIT_LG (UNIT_LG),
        .CNT_W   (CNT_W)
    ) u_sizer (
        .maxp_i  (req_maxp_i),
        .slot_i  (slot_eff),
        .units_o (units_req)
    );

    assign m_start = (r_q.st == FS_IDLE) ? fstart : OFS_W'(r_q.run_start);
    assign m_len   = (r_q.st == FS_IDLE) ? units_req : r_q.need;

    fseg_mask #(
        .UNITS (UNITS),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) u_mask (
        .start_i (m_start),
        .len_i   (m_len),
        .mask_o  (run_mask)
    );

    assign range_bad = ({1'b0, fstart} + (OFS_W+1)'(units_req)) > (OFS_W+1)'(lim_eff);
    assign clear_bad = |(run_mask & ~r_q.bmap);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        r_d.ferr = 1'b0;
        unique case (r_q.st)
            FS_IDLE: begin
                if (req_valid_i) begin
                    if (!req_free_i) begin
                        r_d.need      = units_req;
                        r_d.limit     = lim_eff;
                        r_d.base      = base_addr_i;
                        r_d.idx       = '0;
                        r_d.run_start = '0;
                        r_d.run_len   = '0;
                        r_d.st        = FS_SCAN;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.addr = base_addr_i + (ADDR_W'(fstart) << UNIT_LG);
                        if (range_bad || clear_bad) begin
                            r_d.ferr = 1'b1;
                        end else begin
                            r_d.bmap = r_q.bmap & ~run_mask;
                        end
                    end
                end
            end
            FS_SCAN: begin
                if (r_q.idx >= r_q.limit) begin
                    r_d.done = 1'b1;
                    r_d.fail = 1'b1;
                    r_d.st   = FS_IDLE;
                end else if (r_q.bmap[r_q.idx[IDX_W-1:0]]) begin
                    r_d.run_len   = '0;
                    r_d.run_start = r_q.idx + CNT_W'(1);
                    r_d.idx       = r_q.idx + CNT_W'(1);
                end else if (r_q.run_len + CNT_W'(1) == r_q.need) begin
                    r_d.bmap = r_q.bmap | run_mask;
                    r_d.done = 1'b1;
                    r_d.addr = r_q.base + (ADDR_W'(r_q.run_start) << UNIT_LG);
                    r_d.st   = FS_IDLE;
                end else begin
                    r_d.run_len = r_q.run_len + CNT_W'(1);
                    r_d.idx     = r_q.idx + CNT_W'(1);
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: FS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o = (r_q.st == FS_IDLE);
    assign done_o      = r_q.done;
    assign fail_o      = r_q.fail;
    assign free_err_o  = r_q.ferr;
    assign rsp_addr_o  = r_q.addr;
endmodule

// File: rtl/fseg_alloc_chk.sv
`timescale 1ns/1ps
module fseg_alloc_chk #(
    parameter int UNITS   = 128,
    parameter int UNIT_LG = 9,
    parameter int ADDR_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_ready_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              free_err_o,
    input logic [ADDR_W-1:0] rsp_addr_o,
    input logic [ADDR_W-1:0] base_addr_i
);
    localparam int BW = $clog2(UNITS) + 3;
    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_cnt <= '0;
        end else if (!req_ready_o) begin
            busy_cnt <= busy_cnt + BW'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    a_r8_bounded_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_cnt <= BW'(UNITS + 1));
    a_r9_fail_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> done_o);
    a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        free_err_o |-> done_o);
    a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fail_o && free_err_o));
    a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(rsp_addr_o));
    a_r9_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> req_ready_o);
    a_r4_unit_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !fail_o) |-> (rsp_addr_o[UNIT_LG-1:0] == base_addr_i[UNIT_LG-1:0]));
endmodule

bind fifo_seg_alloc fseg_alloc_chk #(
    .UNITS   (UNITS),
    .UNIT_LG (UNIT_LG),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ready_o (req_ready_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .free_err_o  (free_err_o),
    .rsp_addr_o  (rsp_addr_o),
    .base_addr_i (base_addr_i)
);

// File: tb/fifo_seg_alloc_test.sv
`timescale 1ns/1ps
module fifo_seg_alloc_test;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = BASE;
    logic [7:0]  unit_limit = 8'd128;
    logic        req_valid = 1'b0;
    logic        req_free = 1'b0;
    logic [10:0] req_maxp = '0;
    logic [2:0]  req_slot = '0;
    logic        req_dflt = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, done, fail, ferr;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fifo_seg_alloc uut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .base_addr_i     (base_addr),
        .unit_limit_i    (unit_limit),
        .req_valid_i     (req_valid),
        .req_free_i      (req_free),
        .req_maxp_i      (req_maxp),
        .req_slot_i      (req_slot),
        .req_dflt_slot_i (req_dflt),
        .req_addr_i      (req_addr),
        .req_ready_o     (req_ready),
        .done_o          (done),
        .fail_o          (fail),
        .free_err_o      (ferr),
        .rsp_addr_o      (rsp_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit fr, input int maxp, input int slot, input bit dflt,
                          input logic [31:0] a, output logic [31:0] ra,
                          output bit f, output bit e, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_free = fr; req_maxp = 11'(maxp);
        req_slot = 3'(slot); req_dflt = dflt; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R8 request timeout actual=%0d expected<400", cyc);
        end
        ra = rsp_addr; f = fail; e = ferr;
    endtask

    task automatic alloc_expect(input string tag, input int maxp, input int slot,
                                input bit dflt, input logic [31:0] exp_addr);
        logic [31:0] ra; bit f, e; int cyc;
        do_req(1'b0, maxp, slot, dflt, '0, ra, f, e, cyc);
        chk({tag, " fail flag"}, 32'(f), 32'd0);
        chk({tag, " address"}, ra, exp_addr);
    endtask

    task automatic free_expect(input string tag, input int maxp, input int slot,
                               input logic [31:0] a, input bit exp_err);
        logic [31:0] ra; bit f, e; int cyc;
        do_req(1'b1, maxp, slot, 1'b0, a, ra, f, e, cyc);
        chk({tag, " error flag"}, 32'(e), 32'(exp_err));
        chk({tag, " cycles"}, 32'(cyc), 32'd1);
        chk({tag, " echo address"}, ra, a);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 flags after reset", 32'({fail, ferr}), 32'd0);
        chk("R1 address after reset", rsp_addr, 32'd0);
    endtask

    task automatic t_basic_alloc();
        alloc_expect("R1 R4 first alloc 2 units", 512, 1, 1'b0, BASE);
        alloc_expect("R2 maxp 100 rounds to 1 unit", 100, 0, 1'b0, BASE + 32'h400);
        alloc_expect("R2 maxp 1024 slot 2 is 6 units", 1024, 2, 1'b0, BASE + 32'h600);
    endtask

    task automatic t_default_slot();
        alloc_expect("R3 default slot gives 6 units", 513, 0, 1'b1, BASE + 32'h1200);
    endtask

    task automatic t_free_refill();
        free_expect("R6 free units 3..8", 1024, 2, BASE + 32'h600, 1'b0);
        alloc_expect("R4 refill 4 units at 3", 512, 3, 1'b0, BASE + 32'h600);
        alloc_expect("R6 unit 7 now free", 1, 0, 1'b0, BASE + 32'hE00);
    endtask

    task automatic t_double_free();
        free_expect("R7 free over clear unit", 1024, 2, BASE + 32'h600, 1'b1);
        alloc_expect("R7 map unchanged after bad free", 1, 0, 1'b0, BASE + 32'h1000);
    endtask

    task automatic t_limit();
        logic [31:0] ra; bit f, e; int cyc;
        unit_limit = 8'd16;
        do_req(1'b0, 512, 1, 1'b0, '0, ra, f, e, cyc);
        chk("R5 no fit below limit fails", 32'(f), 32'd1);
        chk("R8 search bound", 32'(cyc <= 18), 32'd1);
        alloc_expect("R5 map unchanged after fail", 1, 0, 1'b0, BASE + 32'h1E00);
        unit_limit = 8'd18;
        alloc_expect("R5 run ending at limit", 512, 1, 1'b0, BASE + 32'h2000);
        free_expect("R7 free past limit", 512, 3, BASE + 32'h2000, 1'b1);
        free_expect("R6 free units 16..17", 512, 1, BASE + 32'h2000, 1'b0);
        unit_limit = 8'd128;
    endtask

    task automatic t_busy_ignore();
        int cyc;
        @(negedge clk);
        req_valid = 1'b1; req_free = 1'b0; req_maxp = 11'd2047;
        req_slot = 3'd3; req_dflt = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 not ready while searching", 32'(req_ready), 32'd0);
        req_valid = 1'b1; req_free = 1'b1; req_maxp = 11'd512;
        req_slot = 3'd1; req_addr = BASE;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 2;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8 search completes in bound", 32'(cyc <= 130), 32'd1);
        chk("R4 16 units at 16", rsp_addr, BASE + 32'h2000);
        chk("R9 no error on alloc", 32'({fail, ferr}), 32'd0);
        alloc_expect("R8 free during search ignored", 512, 1, 1'b0, BASE + 32'h4000);
        alloc_expect("R2 maxp 600 rounds to 2 units", 600, 0, 1'b0, BASE + 32'h4400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_alloc();
        t_default_slot();
        t_free_refill();
        t_double_free();
        t_limit();
        t_busy_ignore();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule